// File: doc/BRIEF.md
# Enhanced Parallel Cycle Gate

This block sits next to a parallel port's control register and decides whether host accesses to the enhanced-parallel address register (offset 3) and data register (offset 4) turn into a cycle on an external peripheral interface. A write goes out only when the control byte selects forward direction with every handshake line idle except the initialise line. A read goes out only when the control byte selects reverse direction in that same idle pattern. Accesses that do not meet the rule complete at once. A dropped write leaves no trace. A dropped read returns all ones at the access width.

A forwarded access raises a request and holds it until the peripheral acknowledges it or a cycle budget runs out. A request that runs out sets a sticky timeout flag. The host sees that flag as bit 0 of the status byte at offset 1. The flag clears only when the host writes status with bit 0 set, or on reset. The host side stalls with `host_ready` low while a forwarded access is in flight.

The controller has four states. S_IDLE accepts host accesses. Every non-forwarded access completes in S_IDLE in the cycle it is presented. A forwarded access takes transition IDLE->XFER. S_XFER drives the request. It takes XFER->DONE when acknowledge is seen. It takes XFER->FAIL when the budget is used up without acknowledge. S_DONE and S_FAIL each present the response for one cycle and then take DONE->IDLE or FAIL->IDLE.

Top module: `epp_gate`

## Requirements
- R1: A write to offset 3 or 4 is forwarded only when `ctrl_reg & 8'h2F == 8'h04`. The mask covers direction bit 5, select bit 3, initialise bit 2, auto-feed bit 1 and strobe bit 0. Any other write to those offsets raises no request and completes with `host_ready` high in the cycle it is presented.
- R2: A read from offset 3 or 4 is forwarded only when `ctrl_reg & 8'h2F == 8'h24`. Any other such read raises no request, completes in its first cycle and returns all ones at the access width.
- R3: `host_size` codes 0, 1 and 2 select 1, 2 and 4 bytes, and code 3 acts as 4 bytes. Byte lane 0 is bits 7:0 and higher lanes follow in little-endian order. Lanes beyond the width are zero on `per_wdata` and on `host_rdata`. Offset 3 is always one byte wide (`per_size` = 0), whatever `host_size` says.
- R4: A forwarded access raises `per_req` starting the cycle after acceptance. While `per_req` is high, `per_addr_sel` (1 for offset 3), `per_wr`, `per_size` and `per_wdata` stay constant, and `host_ready` stays low.
- R5: If `per_ack` is not seen within TIMEOUT_CYCLES request cycles, the request drops and the timeout flag sets. A read that ends this way returns all ones at its width. An acknowledge in the last allowed cycle still succeeds. `per_req` is never high for more than TIMEOUT_CYCLES consecutive cycles.
- R6: A successful forwarded read returns `per_rdata`, sampled in the acknowledge cycle and masked to the access width. The host sees it one cycle after acknowledge, with `host_ready` high.
- R7: A status read at offset 1 completes in one cycle. It returns `ext_status[7:1]` with bit 0 replaced by the timeout flag, with upper lanes zero.
- R8: A status write with bit 0 set clears the timeout flag. A status write with bit 0 clear leaves the flag unchanged. Only a failed forwarded access sets the flag.
- R9: Reset returns the controller to S_IDLE with the timeout flag clear.
- R10: Offsets 0, 2, 5, 6 and 7 raise no request and complete in one cycle. Reads from them return all ones at the access width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_reg | input | 8 | Current port control byte |
| ext_status | input | 8 | Status lines from the port |
| host_valid | input | 1 | Host access present |
| host_write | input | 1 | 1 = write, 0 = read |
| host_offset | input | 3 | Register offset |
| host_size | input | 2 | Access width code |
| host_wdata | input | DATA_W | Host write data, lane 0 in bits 7:0 |
| host_ready | output | 1 | Access completes at this clock edge |
| host_rdata | output | DATA_W | Read data, valid with host_ready |
| per_req | output | 1 | Peripheral cycle request |
| per_addr_sel | output | 1 | 1 = address cycle, 0 = data cycle |
| per_wr | output | 1 | 1 = write cycle |
| per_size | output | 2 | Width code of the cycle |
| per_wdata | output | DATA_W | Write data of the cycle |
| per_ack | input | 1 | Peripheral acknowledge |
| per_rdata | input | DATA_W | Peripheral read data |

## Verification
The assertions assume the host holds `host_valid` and its command fields steady from the cycle it presents them until the edge where `host_ready` is high. They also assume the host drops `host_valid`, or presents a new access, right after that edge. The bench's host task drives each access on a falling edge, holds it until it sees ready, and releases it just after the completing edge. Its peripheral model raises acknowledge only while a request is high, after a chosen delay that sometimes lies past the cycle budget. Control bytes are drawn so that both open patterns and arbitrary patterns occur often.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_XFER = 2'd1,
        S_DONE = 2'd2,
        S_FAIL = 2'd3
    } state_e;

    typedef enum logic [1:0] {
        ACC_STATUS = 2'd0,
        ACC_FWD    = 2'd1,
        ACC_DROP   = 2'd2,
        ACC_OTHER  = 2'd3
    } acc_e;

    localparam logic [2:0] OFS_STATUS = 3'd1;
    localparam logic [2:0] OFS_ADDR   = 3'd3;
    localparam logic [2:0] OFS_DATA   = 3'd4;

    localparam logic [7:0] CTL_DIR    = 8'h20;
    localparam logic [7:0] CTL_SELECT = 8'h08;
    localparam logic [7:0] CTL_INIT   = 8'h04;
    localparam logic [7:0] CTL_AUTOLF = 8'h02;
    localparam logic [7:0] CTL_STROBE = 8'h01;

    localparam logic [7:0] CTL_GATE_MASK = CTL_DIR | CTL_SELECT | CTL_INIT | CTL_AUTOLF | CTL_STROBE;
    localparam logic [7:0] CTL_WR_OPEN   = CTL_INIT;
    localparam logic [7:0] CTL_RD_OPEN   = CTL_DIR | CTL_INIT;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    function automatic int size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/epp_access_decode.sv
module epp_access_decode
    import epp_gate_pkg::*;
(
    input  logic [2:0] offset,
    input  logic       write,
    input  logic [1:0] size,
    input  logic [7:0] ctrl,
    output acc_e       kind,
    output logic       addr_sel,
    output logic [1:0] eff_size
);

    logic [7:0] gated;
    logic       open_now;

    always_comb begin
        gated    = ctrl & CTL_GATE_MASK;
        addr_sel = (offset == OFS_ADDR);
        // the address register only ever moves one byte
        eff_size = addr_sel ? SZ_BYTE : size;
        open_now = write ? (gated == CTL_WR_OPEN) : (gated == CTL_RD_OPEN);
        if (offset == OFS_STATUS) begin
            kind = ACC_STATUS;
        end else if (offset == OFS_ADDR || offset == OFS_DATA) begin
            kind = open_now ? ACC_FWD : ACC_DROP;
        end else begin
            kind = ACC_OTHER;
        end
    end

endmodule

// File: rtl/epp_cycle_timer.sv
module epp_cycle_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);

    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    // expired marks the last request cycle the budget allows
    assign expired = run && (cnt_q == CNT_W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/epp_lane_mask.sv
module epp_lane_mask
    import epp_gate_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] dout
);

    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0] lane_en;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_en[g]        = (g < size_bytes(size));
        assign dout[g*8 +: 8]    = lane_en[g] ? din[g*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/epp_gate.sv
module epp_gate
    import epp_gate_pkg::*;
#(
    parameter int DATA_W         = 32,
    parameter int TIMEOUT_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        ctrl_reg,
    input  logic [7:0]        ext_status,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [2:0]        host_offset,
    input  logic [1:0]        host_size,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              per_req,
    output logic              per_addr_sel,
    output logic              per_wr,
    output logic [1:0]        per_size,
    output logic [DATA_W-1:0] per_wdata,
    input  logic              per_ack,
    input  logic [DATA_W-1:0] per_rdata
);

    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    state_e            state_q, state_d;
    acc_e              dec_kind;
    logic              dec_sel;
    logic [1:0]        dec_size;
    logic              accept_fwd;
    logic              clear_hit;
    logic              budget_out;

    logic              req_wr_q;
    logic              req_sel_q;
    logic [1:0]        req_size_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic [DATA_W-1:0] rsp_q;
    logic              timeout_q;

    logic [DATA_W-1:0] wdata_m;
    logic [DATA_W-1:0] rdata_m;
    logic [DATA_W-1:0] ones_now;
    logic [DATA_W-1:0] ones_req;
    logic [7:0]        status_byte;
    logic [DATA_W-1:0] status_word;

    epp_access_decode u_decode (
        .offset   (host_offset),
        .write    (host_write),
        .size     (host_size),
        .ctrl     (ctrl_reg),
        .kind     (dec_kind),
        .addr_sel (dec_sel),
        .eff_size (dec_size)
    );

    epp_cycle_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept_fwd),
        .run     (state_q == S_XFER),
        .expired (budget_out)
    );

    epp_lane_mask #(.DATA_W(DATA_W)) u_mask_wr (
        .din (host_wdata), .size (dec_size), .dout (wdata_m)
    );

    epp_lane_mask #(.DATA_W(DATA_W)) u_mask_rd (
        .din (per_rdata), .size (req_size_q), .dout (rdata_m)
    );

    epp_lane_mask #(.DATA_W(DATA_W)) u_mask_ones_now (
        .din (ALL_ONES), .size (dec_size), .dout (ones_now)
    );

    epp_lane_mask #(.DATA_W(DATA_W)) u_mask_ones_req (
        .din (ALL_ONES), .size (req_size_q), .dout (ones_req)
    );

    assign accept_fwd = (state_q == S_IDLE) && host_valid && (dec_kind == ACC_FWD);
    assign clear_hit  = (state_q == S_IDLE) && host_valid && host_write &&
                        (dec_kind == ACC_STATUS) && host_wdata[0];

    always_comb begin
        status_byte    = ext_status;
        status_byte[0] = timeout_q;
        status_word    = '0;
        status_word[7:0] = status_byte;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: IDLE->XFER, XFER->DONE, XFER->FAIL, DONE->IDLE, FAIL->IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept_fwd) state_d = S_XFER;
            S_XFER: begin
                if (per_ack)         state_d = S_DONE;
                else if (budget_out) state_d = S_FAIL;
            end
            S_DONE: state_d = S_IDLE;
            S_FAIL: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // request capture, response capture and the sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_wr_q    <= 1'b0;
            req_sel_q   <= 1'b0;
            req_size_q  <= SZ_BYTE;
            req_wdata_q <= '0;
            rsp_q       <= '0;
            timeout_q   <= 1'b0;
        end else begin
            if (accept_fwd) begin
                req_wr_q    <= host_write;
                req_sel_q   <= dec_sel;
                req_size_q  <= dec_size;
                req_wdata_q <= host_write ? wdata_m : '0;
            end
            if (state_q == S_XFER && per_ack) begin
                rsp_q <= req_wr_q ? '0 : rdata_m;
            end
            if (state_q == S_XFER && !per_ack && budget_out) begin
                timeout_q <= 1'b1;
            end else if (clear_hit) begin
                timeout_q <= 1'b0;
            end
        end
    end

    // outputs per state
    always_comb begin
        host_ready = 1'b0;
        host_rdata = '0;
        per_req    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                host_ready = host_valid && (dec_kind != ACC_FWD);
                if (!host_write) begin
                    host_rdata = (dec_kind == ACC_STATUS) ? status_word : ones_now;
                end
            end
            S_XFER: begin
                per_req = 1'b1;
            end
            S_DONE: begin
                host_ready = 1'b1;
                host_rdata = rsp_q;
            end
            S_FAIL: begin
                host_ready = 1'b1;
                host_rdata = req_wr_q ? '0 : ones_req;
            end
            default: begin
                host_ready = 1'b0;
            end
        endcase
    end

    assign per_addr_sel = req_sel_q;
    assign per_wr       = req_wr_q;
    assign per_size     = req_size_q;
    assign per_wdata    = req_wdata_q;

endmodule

// File: rtl/epp_gate_chk.sv
module epp_gate_chk #(
    parameter int DATA_W         = 32,
    parameter int TIMEOUT_CYCLES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        ctrl_reg,
    input logic              host_valid,
    input logic              host_write,
    input logic [2:0]        host_offset,
    input logic [1:0]        host_size,
    input logic              host_wdata0,
    input logic              host_ready,
    input logic [DATA_W-1:0] host_rdata,
    input logic              per_req,
    input logic              per_addr_sel,
    input logic              per_wr,
    input logic [1:0]        per_size,
    input logic [DATA_W-1:0] per_wdata,
    input logic              per_ack,
    input logic              flag
);

    localparam int CW = $clog2(TIMEOUT_CYCLES + 2);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= '0;
        else if (per_req) run_q <= run_q + 1'b1;
        else              run_q <= '0;
    end

    AST_WR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_req) && per_wr |-> (($past(ctrl_reg) & 8'h2F) == 8'h04)); // R1

    AST_RD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_req) && !per_wr |-> (($past(ctrl_reg) & 8'h2F) == 8'h24)); // R2

    AST_ADDR_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        per_req && per_addr_sel |-> per_size == 2'd0); // R3

    AST_NARROW_READ: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready && !host_write && host_size == 2'd0 |-> host_rdata[DATA_W-1:8] == '0); // R3

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        per_req && $past(per_req) |-> $stable(per_wdata) && $stable(per_wr) &&
                                      $stable(per_size) && $stable(per_addr_sel)); // R4

    AST_REQ_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_req) |-> per_addr_sel == ($past(host_offset) == 3'd3)); // R4

    AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        per_req |-> !host_ready); // R4

    AST_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CW'(TIMEOUT_CYCLES)); // R5

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(per_req) && !$past(per_ack)); // R8

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(host_valid && host_ready && host_write &&
                              host_offset == 3'd1 && host_wdata0)); // R8

endmodule

bind epp_gate epp_gate_chk #(
    .DATA_W         (DATA_W),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
) u_epp_gate_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_reg     (ctrl_reg),
    .host_valid   (host_valid),
    .host_write   (host_write),
    .host_offset  (host_offset),
    .host_size    (host_size),
    .host_wdata0  (host_wdata[0]),
    .host_ready   (host_ready),
    .host_rdata   (host_rdata),
    .per_req      (per_req),
    .per_addr_sel (per_addr_sel),
    .per_wr       (per_wr),
    .per_size     (per_size),
    .per_wdata    (per_wdata),
    .per_ack      (per_ack),
    .flag         (timeout_q)
);

// File: tb/epp_gate_tb_top.sv
module epp_gate_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 8;
    localparam int N_RANDOM   = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ctrl_reg = 8'h00;
    logic [7:0]  ext_status = 8'h00;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [2:0]  host_offset = 3'd0;
    logic [1:0]  host_size = 2'd0;
    logic [31:0] host_wdata = '0;
    logic        host_ready;
    logic [31:0] host_rdata;
    logic        per_req;
    logic        per_addr_sel;
    logic        per_wr;
    logic [1:0]  per_size;
    logic [31:0] per_wdata;
    logic        per_ack = 1'b0;
    logic [31:0] per_rdata = '0;

    epp_gate #(.DATA_W(32), .TIMEOUT_CYCLES(TMO)) dut_i (
        .clk (clk), .rst_n (rst_n), .ctrl_reg (ctrl_reg), .ext_status (ext_status),
        .host_valid (host_valid), .host_write (host_write), .host_offset (host_offset),
        .host_size (host_size), .host_wdata (host_wdata), .host_ready (host_ready),
        .host_rdata (host_rdata), .per_req (per_req), .per_addr_sel (per_addr_sel),
        .per_wr (per_wr), .per_size (per_size), .per_wdata (per_wdata),
        .per_ack (per_ack), .per_rdata (per_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          checks = 0;
    int          failures = 0;
    bit          exp_flag = 1'b0;
    int          ack_delay = 1;
    logic [31:0] model_rdata = '0;
    int          m_cnt = 0;
    int          m_total = 0;
    logic        cap_sel = 1'b0;
    logic        cap_wr = 1'b0;
    logic [1:0]  cap_size = 2'd0;
    logic [31:0] cap_wdata = '0;

    // peripheral model: acknowledges in the ack_delay-th request cycle
    always @(negedge clk) begin
        if (per_req) begin
            m_cnt = m_cnt + 1;
            if (m_cnt == 1) begin
                cap_sel   = per_addr_sel;
                cap_wr    = per_wr;
                cap_size  = per_size;
                cap_wdata = per_wdata;
            end
            m_total   = m_cnt;
            per_ack   = (m_cnt == ack_delay);
            per_rdata = model_rdata;
        end else begin
            m_cnt   = 0;
            per_ack = 1'b0;
        end
    end

    function automatic logic [31:0] width_ones(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic bit gate_open(input logic [7:0] c, input bit wr);
        return wr ? ((c & 8'h2F) == 8'h04) : ((c & 8'h2F) == 8'h24);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        host_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_flag = 1'b0;
    endtask

    task automatic access(input bit wr, input logic [2:0] ofs, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd, output int waits);
        bit got;
        got = 1'b0;
        waits = 0;
        rd = '0;
        @(negedge clk);
        m_total     = 0;
        host_valid  = 1'b1;
        host_write  = wr;
        host_offset = ofs;
        host_size   = sz;
        host_wdata  = wd;
        while (!got) begin
            #(CLK_PERIOD/4);
            if (host_ready) begin
                rd  = host_rdata;
                got = 1'b1;
            end else begin
                waits++;
                @(negedge clk);
            end
        end
        @(posedge clk);
        #1;
        host_valid = 1'b0;
    endtask

    // one access plus all checks derived from the requirements
    task automatic run_one(input bit wr, input logic [2:0] ofs, input logic [1:0] sz,
                           input logic [31:0] wd);
        logic [31:0] rd;
        int          waits;
        logic [1:0]  esz;
        logic [31:0] msk;
        bit          fwd;
        bit          ok_ack;
        logic [31:0] exp_st;
        exp_st = {24'h0, ext_status[7:1], exp_flag};
        esz = (ofs == 3'd3) ? 2'd0 : sz;
        msk = width_ones(esz);
        fwd = (ofs == 3'd3 || ofs == 3'd4) && gate_open(ctrl_reg, wr);
        ok_ack = (ack_delay <= TMO);
        access(wr, ofs, sz, wd, rd, waits);
        if (ofs == 3'd1) begin
            chk(waits == 0 && m_total == 0, "R7 status one cycle", waits, 0);
            if (!wr) chk(rd == exp_st, "R7 status value", rd, exp_st);
            else if (wd[0]) exp_flag = 1'b0;
        end else if (ofs == 3'd3 || ofs == 3'd4) begin
            if (!fwd) begin
                chk(waits == 0 && m_total == 0, wr ? "R1 dropped write" : "R2 dropped read",
                    m_total, 0);
                if (!wr) chk(rd == msk, "R2 dropped read ones", rd, msk);
            end else if (ok_ack) begin
                chk(m_total == ack_delay, "R4 request length", m_total, ack_delay);
                chk(waits == ack_delay + 1, "R4 stall cycles", waits, ack_delay + 1);
                chk(cap_sel == (ofs == 3'd3) && cap_wr == wr && cap_size == esz,
                    "R4 request fields", {cap_sel, cap_wr, cap_size}, {(ofs == 3'd3), wr, esz});
                if (wr) chk(cap_wdata == (wd & msk), "R3 write lanes", cap_wdata, wd & msk);
                else    chk(rd == (model_rdata & msk), "R6 read data", rd, model_rdata & msk);
            end else begin
                chk(m_total == TMO, "R5 budget length", m_total, TMO);
                chk(waits == TMO + 1, "R5 stall cycles", waits, TMO + 1);
                if (!wr) chk(rd == msk, "R5 failed read ones", rd, msk);
                exp_flag = 1'b1;
            end
        end else begin
            chk(waits == 0 && m_total == 0, "R10 other offset", m_total, 0);
            if (!wr) chk(rd == width_ones(sz), "R10 other read ones", rd, width_ones(sz));
        end
    endtask

    task automatic check_flag(input string tag);
        logic [31:0] rd;
        int          waits;
        access(1'b0, 3'd1, 2'd0, 32'h0, rd, waits);
        chk(rd[0] == exp_flag, tag, {31'h0, rd[0]}, {31'h0, exp_flag});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, -1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        ext_status = 8'hA7;

        // R9: flag clear after reset
        check_flag("R9 reset flag");
        run_one(1'b0, 3'd1, 2'd2, 32'h0);

        // R1: open write pattern, word data, then a blocked pattern
        ctrl_reg = 8'hC4; ack_delay = 3;
        run_one(1'b1, 3'd4, 2'd2, 32'hDEAD_BEEF);
        run_one(1'b1, 3'd4, 2'd1, 32'h1234_5678);
        run_one(1'b1, 3'd3, 2'd2, 32'hCAFE_F00D);
        ctrl_reg = 8'h24;
        run_one(1'b1, 3'd4, 2'd2, 32'h5555_AAAA);
        ctrl_reg = 8'h05;
        run_one(1'b1, 3'd3, 2'd0, 32'h0000_0011);

        // R2 / R6: reads
        ctrl_reg = 8'h24; ack_delay = 2; model_rdata = 32'h89AB_CDEF;
        run_one(1'b0, 3'd4, 2'd1, 32'h0);
        run_one(1'b0, 3'd4, 2'd3, 32'h0);
        ctrl_reg = 8'h04;
        run_one(1'b0, 3'd4, 2'd2, 32'h0);
        run_one(1'b0, 3'd4, 2'd1, 32'h0);

        // R5: acknowledge in the last allowed cycle, then one cycle late
        ctrl_reg = 8'h24; ack_delay = TMO;
        run_one(1'b0, 3'd4, 2'd0, 32'h0);
        check_flag("R5 no flag on late-but-valid ack");
        ack_delay = TMO + 1;
        run_one(1'b0, 3'd3, 2'd2, 32'h0);
        check_flag("R5 flag after timeout");

        // R8: write with bit 0 clear keeps flag, bit 0 set clears it
        run_one(1'b1, 3'd1, 2'd0, 32'h0000_00FE);
        check_flag("R8 flag kept");
        run_one(1'b1, 3'd1, 2'd0, 32'h0000_0001);
        check_flag("R8 flag cleared");

        // R10: other offsets
        run_one(1'b0, 3'd0, 2'd1, 32'h0);
        run_one(1'b0, 3'd7, 2'd0, 32'h0);
        run_one(1'b1, 3'd2, 2'd2, 32'hFFFF_FFFF);

        // R9: reset clears a set flag
        ctrl_reg = 8'h04; ack_delay = TMO + 2;
        run_one(1'b1, 3'd4, 2'd2, 32'h0102_0304);
        check_flag("R9 flag set before reset");
        do_reset();
        check_flag("R9 flag after reset");

        // constrained random mix
        for (int i = 0; i < N_RANDOM; i++) begin
            int          pick;
            logic [2:0]  ofs;
            pick = int'($urandom_range(0, 3));
            case (pick)
                0:       ctrl_reg = 8'h04 | (8'($urandom) & 8'hC0);
                1:       ctrl_reg = 8'h24 | (8'($urandom) & 8'hC0);
                default: ctrl_reg = 8'($urandom);
            endcase
            case ($urandom_range(0, 7))
                0:       ofs = 3'd1;
                1, 2:    ofs = 3'd3;
                3, 4, 5: ofs = 3'd4;
                6:       ofs = 3'd0;
                default: ofs = 3'($urandom_range(5, 7));
            endcase
            ext_status  = 8'($urandom);
            model_rdata = $urandom;
            ack_delay   = int'($urandom_range(1, TMO + 3));
            run_one(1'($urandom), ofs, 2'($urandom), $urandom);
        end
        check_flag("R8 flag at end of random run");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule